// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a small memory-mapped status register that tells software why the chip last came out of reset. It keeps four sticky flags: one each for watchdog, brown-out and external-pin resets, and one for power-on. Each reset source gives the block a single-cycle event pulse. That pulse sets the matching flag, and the flag then stays set through any later reset that is not a power-on. If software does not clear the flags between resets, several of them can be set at once.

Software reads the register through a read strobe and clears flags by writing zeros through a write strobe. Both strobes are qualified by an address-match select. Writing a one leaves a flag as it is. A power-on condition puts every flag into a known state, so there is no separate reset input.

Each flag is a two-state machine with the states `FLAG_CLR` and `FLAG_SET`:

- **set**: `FLAG_CLR` moves to `FLAG_SET` on its source event.
- **clear**: `FLAG_SET` moves to `FLAG_CLR` on a qualified write of zero, unless the source event arrives in the same cycle.
- **init**: power-on forces either state to the flag's power-on value.

Top module: `rcs_status_reg`

## Requirements
- R1: Bits 7 to 4 always read as zero, and writing ones to them changes nothing.
- R2: While `por_i` is high, on every clock edge bit 0 becomes 1 and bits 3 to 1 become 0, whatever the event inputs are doing.
- R3: A `wdog_evt_i` pulse sets bit 3 at the next clock edge.
- R4: A `brownout_evt_i` pulse sets bit 2 at the next clock edge.
- R5: A `pin_evt_i` pulse sets bit 1 at the next clock edge.
- R6: A set flag stays set until it is explicitly cleared. Events on other sources do not disturb it, so several flags can be set together.
- R7: A write (`sel_i` and `wr_en_i` high) clears, at the next edge, every flag whose data bit is 0. A flag whose data bit is 1 keeps its value.
- R8: When a source event and a write of zero to the same flag happen in the same cycle, the flag ends up set.
- R9: A write with `sel_i` low changes no flag.
- R10: `rd_data_o` is combinational. It equals {4'b0000, bits 3..0} when `sel_i` and `rd_en_i` are both high, and 0 otherwise.
- R11: Bit 0 is set only by power-on and cleared only by a write of zero. The three event inputs never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on condition, active high, level held for at least one cycle |
| wdog_evt_i | input | 1 | Watchdog reset event pulse |
| brownout_evt_i | input | 1 | Brown-out reset event pulse |
| pin_evt_i | input | 1 | External reset pin event pulse |
| sel_i | input | 1 | Address match for this register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data; a 0 bit clears the matching flag |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, zero unless selected for read |

## Verification
The hardest situation to reach is the same-cycle collision between a source event and a software write of zero to that flag. The bench drives both in one cycle while also writing zero to a different flag that is set. In the same write it clears the watchdog flag with its event raised and the pin flag with its event low, so the result shows the set winning beside an ordinary clear. It also applies power-on while all event inputs are high and sets every event after bit 0 has been cleared, which shows that the power-on flag cannot be disturbed by the event inputs.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned FLAG_N   = 4;

    localparam int unsigned POS_POR  = 0;
    localparam int unsigned POS_PIN  = 1;
    localparam int unsigned POS_BOD  = 2;
    localparam int unsigned POS_WDOG = 3;

    typedef enum logic {
        FLAG_CLR = 1'b0,
        FLAG_SET = 1'b1
    } flag_state_e;

endpackage

// File: rtl/rcs_flag_fsm.sv
module rcs_flag_fsm #(
    parameter logic INIT_SET = 1'b0
) (
    input  logic clk_i,
    input  logic init_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import rcs_pkg::*;

    localparam flag_state_e INIT_STATE = INIT_SET ? FLAG_SET : FLAG_CLR;

    flag_state_e state_q;
    flag_state_e state_d;

    // state register: only the power-on condition initialises it
    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    // transitions: init > set > clear
    always_comb begin
        state_d = state_q;
        if (init_i) begin
            state_d = INIT_STATE;
        end else begin
            unique case (state_q)
                FLAG_CLR: if (set_i)            state_d = FLAG_SET;
                FLAG_SET: if (clr_i && !set_i)  state_d = FLAG_CLR;
                default:                        state_d = FLAG_CLR;
            endcase
        end
    end

    // output
    always_comb begin
        flag_o = (state_q == FLAG_SET);
    end

endmodule

// File: rtl/rcs_wr_decode.sv
module rcs_wr_decode #(
    parameter int unsigned REG_W  = rcs_pkg::REG_W,
    parameter int unsigned FLAG_N = rcs_pkg::FLAG_N
) (
    input  logic              sel_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [FLAG_N-1:0] clr_o
);
    localparam int unsigned HI_W = REG_W - FLAG_N;

    logic wr_hit;
    logic unused_hi_bits;

    assign wr_hit         = sel_i && wr_en_i;
    // reserved bits take no part in the write
    assign unused_hi_bits = ^{1'b0, wr_data_i[REG_W-1 -: HI_W]};

    always_comb begin
        for (int i = 0; i < int'(FLAG_N); i++) begin
            clr_o[i] = wr_hit && !wr_data_i[i];
        end
    end

endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg #(
    parameter int unsigned REG_W  = rcs_pkg::REG_W,
    parameter int unsigned FLAG_N = rcs_pkg::FLAG_N
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             wdog_evt_i,
    input  logic             brownout_evt_i,
    input  logic             pin_evt_i,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [REG_W-1:0] rd_data_o
);
    import rcs_pkg::*;

    localparam int unsigned PAD_W = REG_W - FLAG_N;

    logic [FLAG_N-1:0] src_evt;
    logic [FLAG_N-1:0] clr_req;
    logic [FLAG_N-1:0] flag_q;

    always_comb begin
        src_evt           = '0;
        src_evt[POS_WDOG] = wdog_evt_i;
        src_evt[POS_BOD]  = brownout_evt_i;
        src_evt[POS_PIN]  = pin_evt_i;
    end

    rcs_wr_decode #(
        .REG_W  (REG_W),
        .FLAG_N (FLAG_N)
    ) i_wr_decode (
        .sel_i     (sel_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_o     (clr_req)
    );

    for (genvar g = 0; g < int'(FLAG_N); g++) begin : g_flag
        if (g == int'(POS_POR)) begin : g_por
            rcs_flag_fsm #(.INIT_SET(1'b1)) i_flag (
                .clk_i  (clk_i),
                .init_i (por_i),
                .set_i  (1'b0),
                .clr_i  (clr_req[g]),
                .flag_o (flag_q[g])
            );
        end else begin : g_src
            rcs_flag_fsm #(.INIT_SET(1'b0)) i_flag (
                .clk_i  (clk_i),
                .init_i (por_i),
                .set_i  (src_evt[g]),
                .clr_i  (clr_req[g]),
                .flag_o (flag_q[g])
            );
        end
    end

    always_comb begin
        if (sel_i && rd_en_i) begin
            rd_data_o = {{PAD_W{1'b0}}, flag_q};
        end else begin
            rd_data_o = '0;
        end
    end

endmodule

// File: rtl/rcs_status_reg_chk.sv
module rcs_status_reg_chk #(
    parameter int unsigned REG_W  = rcs_pkg::REG_W,
    parameter int unsigned FLAG_N = rcs_pkg::FLAG_N
) (
    input logic              clk_i,
    input logic              por_i,
    input logic              wdog_evt_i,
    input logic              brownout_evt_i,
    input logic              pin_evt_i,
    input logic              sel_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic              rd_en_i,
    input logic [REG_W-1:0]  rd_data_o,
    input logic [FLAG_N-1:0] flag_q
);

    a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (por_i)
        rd_data_o[REG_W-1:FLAG_N] == '0);

    a_r2_por_init: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(por_i) |-> flag_q == 4'b0001);

    a_r3_wdog_sets: assert property (@(posedge clk_i) disable iff (por_i)
        wdog_evt_i |=> flag_q[3]);

    a_r4_bod_sets: assert property (@(posedge clk_i) disable iff (por_i)
        brownout_evt_i |=> flag_q[2]);

    a_r5_pin_sets: assert property (@(posedge clk_i) disable iff (por_i)
        pin_evt_i |=> flag_q[1]);

    a_r6_sticky: assert property (@(posedge clk_i) disable iff (por_i)
        (flag_q[2] && !(sel_i && wr_en_i)) |=> flag_q[2]);

    a_r7_write_zero_clears: assert property (@(posedge clk_i) disable iff (por_i)
        (sel_i && wr_en_i && !wr_data_i[3] && !wdog_evt_i) |=> !flag_q[3]);

    a_r7_write_one_keeps: assert property (@(posedge clk_i) disable iff (por_i)
        (sel_i && wr_en_i && wr_data_i[0]) |=> $stable(flag_q[0]));

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (por_i)
        (sel_i && wr_en_i && !wr_data_i[1] && pin_evt_i) |=> flag_q[1]);

    a_r9_unselected_write: assert property (@(posedge clk_i) disable iff (por_i)
        (!sel_i && !wdog_evt_i && !brownout_evt_i && !pin_evt_i) |=> $stable(flag_q));

    a_r10_read_gate: assert property (@(posedge clk_i) disable iff (por_i)
        !(sel_i && rd_en_i) |-> rd_data_o == '0);

    a_r11_por_flag_events: assert property (@(posedge clk_i) disable iff (por_i)
        !(sel_i && wr_en_i) |=> $stable(flag_q[0]));

endmodule

bind rcs_status_reg rcs_status_reg_chk #(
    .REG_W  (REG_W),
    .FLAG_N (FLAG_N)
) i_chk (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .wdog_evt_i     (wdog_evt_i),
    .brownout_evt_i (brownout_evt_i),
    .pin_evt_i      (pin_evt_i),
    .sel_i          (sel_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_en_i        (rd_en_i),
    .rd_data_o      (rd_data_o),
    .flag_q         (flag_q)
);

// File: tb/test_rcs_status_reg.sv
module test_rcs_status_reg;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       wd = 1'b0, bo = 1'b0, pin = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    item_t      sb_q[$];
    logic [3:0] model = 4'b0000;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcs_status_reg i_rcs_status_reg (
        .clk_i          (clk),
        .por_i          (por),
        .wdog_evt_i     (wd),
        .brownout_evt_i (bo),
        .pin_evt_i      (pin),
        .sel_i          (sel),
        .wr_en_i        (wr),
        .wr_data_i      (wdata),
        .rd_en_i        (rd),
        .rd_data_o      (rdata)
    );

    // driver: applies one cycle of stimulus, pushes expected read data,
    // then advances the model to the state after the coming edge
    task automatic step(input logic p, input logic w, input logic b,
                        input logic x, input logic s, input logic we,
                        input logic [7:0] d, input logic re, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        por = p; wd = w; bo = b; pin = x;
        sel = s; wr = we; wdata = d; rd = re;
        it.exp = (s && re) ? {4'b0000, model} : 8'h00;
        it.tag = tag;
        sb_q.push_back(it);
        if (p) begin
            model = 4'b0001;
        end else begin
            if (s && we) model = model & d[3:0];
            if (w) model[3] = 1'b1;
            if (b) model[2] = 1'b1;
            if (x) model[1] = 1'b1;
        end
    endtask

    task automatic rdchk(input string tag);
        step(0, 0, 0, 0, 1, 0, 8'h00, 1, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        #3;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (rdata !== it.exp) begin
                bad++;
                $display("FAIL %s rd_data=%h expected=%h", it.tag, rdata, it.exp);
            end
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, 8'h00, 0, "R10 unselected during power-on");
        step(1, 1, 1, 1, 0, 0, 8'h00, 0, "R2 power-on with events");
        rdchk("R2 R11 power-on state");
        step(0, 1, 0, 0, 0, 0, 8'h00, 0, "R3");
        rdchk("R3 watchdog set");
        step(0, 0, 1, 0, 0, 0, 8'h00, 0, "R4");
        rdchk("R4 R6 brown-out set");
        step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R5");
        rdchk("R5 R6 pin set");
        step(0, 0, 0, 0, 1, 1, 8'hFF, 0, "R7 write ones");
        rdchk("R7 R1 write ones keeps flags");
        step(0, 0, 0, 0, 1, 1, 8'hF0, 0, "R7 write zeros");
        rdchk("R7 R1 R11 write zeros clears");
        step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 8'h00, 0, "R10 idle");
        rdchk("R6 sticky pin flag");
        step(0, 1, 0, 0, 1, 1, 8'h00, 0, "R8 collision");
        rdchk("R8 set wins, other cleared");
        step(0, 0, 0, 0, 0, 1, 8'h00, 0, "R9 unselected write");
        rdchk("R9 unselected write ignored");
        step(0, 0, 0, 0, 0, 0, 8'h00, 1, "R10 read without select");
        step(0, 0, 0, 0, 1, 0, 8'h00, 0, "R10 select without read");
        step(0, 0, 1, 1, 0, 0, 8'h00, 0, "R6 two sources");
        rdchk("R6 several flags at once");
        step(1, 0, 0, 0, 0, 0, 8'h00, 0, "R2 power-on again");
        rdchk("R2 power-on clears sourced flags");
        step(0, 0, 0, 0, 1, 1, 8'hFE, 0, "R11 clear bit 0");
        step(0, 1, 1, 1, 0, 0, 8'h00, 0, "R11 all events");
        rdchk("R11 events leave bit 0 clear");
        step(0, 0, 0, 0, 1, 1, 8'h0E, 0, "R7 partial write");
        rdchk("R7 partial write keeps ones");
        step(0, 0, 0, 0, 0, 0, 8'h00, 0, "idle");
        step(0, 0, 0, 0, 0, 0, 8'h00, 0, "idle");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired rd_data=%h expected=done", rdata);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule